// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Management Bus

This block is the management-bus side of a clock generator. A host on an SMBus-style two-wire bus reaches a bank of eight 8-bit control registers through it. The register contents leave the block as one flat parallel vector, so the output-enable, spread, drive-strength and stop-control logic of the clock generator can use them directly. Every register takes a fixed default at reset, so a system that never touches the bus still gets a working clock configuration.

The slave answers to one device address. The command byte that follows the address chooses between single-register access and sequential access. In single access, a 5-bit offset in the command picks the register. In sequential access, the transfer always begins at register 0 and carries a byte count: the host sends the count on a sequential write, and the slave returns it first on a sequential read. Reads use a repeated start after the command. SCL is an input only. SDA is open-drain: the block reads the line and pulls it low through a drive-enable output.

Top module: `clkctl_smb_slave`

## Requirements
- R1: After reset the parallel outputs hold the defaults, register 0 in bits 7:0 up to register 7 in bits 63:56: 0xFF, 0xFF, 0xEB, 0xAF, 0x03, 0x00, 0x10, 0x18. `sda_oe` is low.
- R2: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69. Any other address is not acknowledged, and the bytes that follow it in the same transaction are neither acknowledged nor acted on.
- R3: A command byte whose bits 6:5 are not 00 is not acknowledged. No register changes until the next start.
- R4: A command with bit 7 = 1 selects single access, with bits 4:0 as the offset. On a write, the first data byte goes to that register and is acknowledged. Further data bytes are acknowledged and dropped.
- R5: A single read (command, repeated start, 0xD3) returns the register at the offset, most significant bit first.
- R6: A command with bit 7 = 0 selects sequential access. On a write, the next byte is a count that is acknowledged and otherwise ignored. The data bytes after it fill registers 0, 1, 2 and so on. A stop after any byte leaves the higher registers unchanged.
- R7: A sequential read returns the count 0x08 first, then registers 0 to 7 in ascending order, while the host acknowledges.
- R8: Register 7 is read-only and holds 0x18 (revision 1 in bits 7:4, vendor 8 in bits 3:0). A write to it is acknowledged and has no effect.
- R9: Offsets 8 to 31, and sequential bytes past register 7, are acknowledged on write and change nothing. On read they return 0x00.
- R10: Once the host does not acknowledge a read byte, and also outside transactions, the slave keeps SDA released until the next start.
- R11: Each register write appears on `cfg_q` and is held there until the next write to that register or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open-drain drive enable) |
| cfg_q | output | 64 | Register bank, register n in bits 8n+7:8n |

## Verification
A wrong pointer or role register inside the slave shows up at the ports within one byte time. The symptom is either a missing or extra acknowledge on the next ninth clock, or a wrong byte on the next read. Before that, a corrupted register shows up on `cfg_q` a few system clocks after the acknowledge edge. The bench compares `cfg_q` and the released state of `sda_oe` with its own model on every clock between transactions. A bad write or a drive left on the line is therefore caught well before the next transaction starts.

// File: rtl/clkctl_smb_pkg.sv
package clkctl_smb_pkg;

  localparam int unsigned REG_COUNT = 8;
  localparam logic [6:0]  DEV_ADDR7 = 7'h69;
  localparam logic [7:0]  ID_BYTE   = 8'h18;
  localparam logic [1:0]  CS_MATCH  = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } smb_role_e;

  // Reset value of register idx; the last register is the identification byte.
  function automatic logic [7:0] reg_default(int unsigned idx, int unsigned nreg);
    logic [7:0] v;
    if (idx == nreg - 1) begin
      v = ID_BYTE;
    end else begin
      case (idx)
        0:       v = 8'hFF;
        1:       v = 8'hFF;
        2:       v = 8'hEB;
        3:       v = 8'hAF;
        4:       v = 8'h03;
        5:       v = 8'h00;
        6:       v = 8'h10;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/smb_sync_chain.sv
module smb_sync_chain #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic scl_p;
  logic sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // Data edges while the clock stays high frame a transaction.
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_smb_pkg::*;
#(
  parameter int unsigned NREG = REG_COUNT,
  parameter int          OFFW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFFW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [OFFW-1:0]   rd_idx,
  output logic [7:0]        rd_byte,
  output logic [NREG*8-1:0] cfg_q
);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == NREG - 1) begin : g_ro
        // Identification byte: constant, writes never reach it.
        assign cfg_q[g*8 +: 8] = reg_default(g, NREG);
      end else begin : g_rw
        logic [7:0] val_q;
        logic       hit;
        assign hit = wr_en && (wr_idx == OFFW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   val_q <= reg_default(g, NREG);
          else if (hit) val_q <= wr_data;
        end
        assign cfg_q[g*8 +: 8] = val_q;
      end
    end
  endgenerate

  // Offsets outside the bank read as zero.
  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == OFFW'(i)) rd_byte = cfg_q[i*8 +: 8];
    end
  end

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
  import clkctl_smb_pkg::*;
#(
  parameter int unsigned NREG        = REG_COUNT,
  parameter logic [6:0]  DEV_ADDR    = DEV_ADDR7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);

  localparam int              OFFW     = 5;
  localparam int              PTRW     = $clog2(NREG) + 1;
  localparam logic [PTRW-1:0] PTR_END  = PTRW'(NREG);
  localparam logic [7:0]      CNT_BYTE = 8'(NREG);

  // Reset: asserted at once, released on a clock edge.
  logic rst_meta;
  logic rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Bus line conditioning.
  logic [1:0] line_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       ev_start;
  logic       ev_stop;

  smb_sync_chain #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     ({scl_i, sda_i}),
    .q     (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smb_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_q),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  // Protocol state.
  smb_state_e      state_q,  n_state;
  smb_role_e       role_q,   n_role;
  logic [3:0]      bitcnt_q, n_bitcnt;
  logic [7:0]      rx_q,     n_rx;
  logic [7:0]      tx_q,     n_tx;
  logic            oe_q,     n_oe;
  logic            rd_q,     n_rd;
  logic            bmode_q,  n_bmode;
  logic [OFFW-1:0] off_q,    n_off;
  logic [PTRW-1:0] blk_q,    n_blk;
  logic            cntp_q,   n_cntp;
  logic            hack_q,   n_hack;
  logic            bdone_q,  n_bdone;

  logic            wr_en;
  logic [OFFW-1:0] wr_idx;
  logic [OFFW-1:0] rd_idx;
  logic [7:0]      rd_byte;
  logic [7:0]      tx_load;
  logic            load_tx;

  clkctl_regbank #(.NREG(NREG), .OFFW(OFFW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (rx_q),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte),
    .cfg_q   (cfg_q)
  );

  assign rd_idx  = bmode_q ? off_q : OFFW'(blk_q);
  assign tx_load = cntp_q ? CNT_BYTE : rd_byte;

  always_comb begin
    n_state  = state_q;
    n_role   = role_q;
    n_bitcnt = bitcnt_q;
    n_rx     = rx_q;
    n_tx     = tx_q;
    n_oe     = oe_q;
    n_rd     = rd_q;
    n_bmode  = bmode_q;
    n_off    = off_q;
    n_blk    = blk_q;
    n_cntp   = cntp_q;
    n_hack   = hack_q;
    n_bdone  = bdone_q;
    wr_en    = 1'b0;
    wr_idx   = bmode_q ? off_q : OFFW'(blk_q);
    load_tx  = 1'b0;

    if (ev_stop) begin
      n_state = ST_IDLE;
      n_oe    = 1'b0;
    end else if (ev_start) begin
      n_state  = ST_RX;
      n_role   = RL_ADDR;
      n_bitcnt = 4'd0;
      n_oe     = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            n_rx     = {rx_q[6:0], sda_s};
            n_bitcnt = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            n_bitcnt = 4'd0;
            case (role_q)
              RL_ADDR: begin
                if (rx_q[7:1] == DEV_ADDR) begin
                  n_state = ST_ACK;
                  n_oe    = 1'b1;
                  n_rd    = rx_q[0];
                  n_role  = RL_CMD;
                  if (rx_q[0]) begin
                    n_blk  = '0;
                    n_cntp = ~bmode_q;
                  end
                end else begin
                  n_state = ST_IDLE;
                end
              end
              RL_CMD: begin
                if (rx_q[6:5] == CS_MATCH) begin
                  n_state = ST_ACK;
                  n_oe    = 1'b1;
                  n_bmode = rx_q[7];
                  n_off   = rx_q[OFFW-1:0];
                  n_blk   = '0;
                  n_bdone = 1'b0;
                  n_role  = rx_q[7] ? RL_DATA : RL_CNT;
                end else begin
                  n_state = ST_IDLE;
                end
              end
              RL_CNT: begin
                n_state = ST_ACK;
                n_oe    = 1'b1;
                n_role  = RL_DATA;
              end
              default: begin
                n_state = ST_ACK;
                n_oe    = 1'b1;
                if (bmode_q) begin
                  wr_en   = ~bdone_q;
                  n_bdone = 1'b1;
                end else begin
                  wr_en = 1'b1;
                  if (blk_q != PTR_END) n_blk = blk_q + PTRW'(1);
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              load_tx = 1'b1;
            end else begin
              n_state = ST_RX;
              n_oe    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              n_state  = ST_HACK;
              n_oe     = 1'b0;
              n_bitcnt = 4'd0;
            end else begin
              n_bitcnt = bitcnt_q + 4'd1;
              n_tx     = {tx_q[6:0], 1'b0};
              n_oe     = ~tx_q[6];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            n_hack = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              load_tx = 1'b1;
            end else begin
              n_state = ST_IDLE;
              n_oe    = 1'b0;
            end
          end
        end
        default: n_state = ST_IDLE;
      endcase
    end

    if (load_tx) begin
      n_state  = ST_TX;
      n_tx     = tx_load;
      n_oe     = ~tx_load[7];
      n_bitcnt = 4'd0;
      if (cntp_q) begin
        n_cntp = 1'b0;
      end else if (!bmode_q && blk_q != PTR_END) begin
        n_blk = blk_q + PTRW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= ST_IDLE;
      role_q   <= RL_ADDR;
      bitcnt_q <= 4'd0;
      rx_q     <= 8'h00;
      tx_q     <= 8'h00;
      oe_q     <= 1'b0;
      rd_q     <= 1'b0;
      bmode_q  <= 1'b0;
      off_q    <= '0;
      blk_q    <= '0;
      cntp_q   <= 1'b0;
      hack_q   <= 1'b0;
      bdone_q  <= 1'b0;
    end else begin
      state_q  <= n_state;
      role_q   <= n_role;
      bitcnt_q <= n_bitcnt;
      rx_q     <= n_rx;
      tx_q     <= n_tx;
      oe_q     <= n_oe;
      rd_q     <= n_rd;
      bmode_q  <= n_bmode;
      off_q    <= n_off;
      blk_q    <= n_blk;
      cntp_q   <= n_cntp;
      hack_q   <= n_hack;
      bdone_q  <= n_bdone;
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/clkctl_smb_checker.sv
module clkctl_smb_checker
  import clkctl_smb_pkg::*;
#(
  parameter int unsigned NREG = REG_COUNT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              wr_en,
  input logic [4:0]        wr_idx,
  input smb_state_e        state,
  input logic [NREG*8-1:0] cfg_q
);

  // R1: no drive on the data line while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !sda_oe);

  // R10: an idle slave never pulls the line
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5: the slave only starts driving while the clock line is low
  a_r5_drive_at_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: a register write is a single-cycle pulse, issued in the low clock phase
  a_r11_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r11_write_at_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);

  // R8: a write aimed at the identification byte leaves it unchanged
  a_r8_id_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 5'(NREG - 1)) |=> $stable(cfg_q[NREG*8-1 -: 8]));

endmodule

bind clkctl_smb_slave clkctl_smb_checker #(.NREG(NREG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_q),
  .sda_oe (oe_q),
  .scl_s  (scl_s),
  .wr_en  (wr_en),
  .wr_idx (wr_idx),
  .state  (state_q),
  .cfg_q  (cfg_q)
);

// File: tb/clkctl_smb_slave_bench.sv
`timescale 1ns/1ps
module clkctl_smb_slave_bench;

  localparam int NREG = 8;
  localparam int Q    = 8;

  logic clk;
  logic rst_n;
  logic scl_drv;
  logic host_low;
  logic sda_line;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_q;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_line = ~(host_low | sda_oe);

  clkctl_smb_slave u_clkctl_smb_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_drv),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .cfg_q  (cfg_q)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_en = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] mreg [NREG];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] mflat();
    logic [NREG*8-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = mreg[i];
    return r;
  endfunction

  // R1 defaults, register 0 first
  task automatic model_defaults();
    mreg[0] = 8'hFF; mreg[1] = 8'hFF; mreg[2] = 8'hEB; mreg[3] = 8'hAF;
    mreg[4] = 8'h03; mreg[5] = 8'h00; mreg[6] = 8'h10; mreg[7] = 8'h18;
  endtask

  // Model writes: register 7 and offsets beyond the bank are dropped (R8, R9)
  task automatic model_write(input int idx, input logic [7:0] v);
    if (idx < NREG - 1) mreg[idx] = v;
  endtask

  function automatic logic [7:0] model_read(input int idx);
    return (idx < NREG) ? mreg[idx] : 8'h00;
  endfunction

  // Between transactions: compare every clock (R11, R10)
  always @(negedge clk) begin
    if (mon_en) begin
      chk("R11 cfg_q against model", 64'(cfg_q), 64'(mflat()));
      chk("R10 sda_oe released between transactions", {63'b0, sda_oe}, 64'd0);
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic bus_start();
    mon_en   = 1'b0;
    host_low = 1'b0; qw();
    scl_drv  = 1'b1; qw();
    host_low = 1'b1; qw();
    scl_drv  = 1'b0; qw();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; qw();
    scl_drv  = 1'b1; qw();
    host_low = 1'b0; qw();
  endtask

  task automatic tx8(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; qw();
      scl_drv  = 1'b1;  qw(); qw();
      scl_drv  = 1'b0;
    end
    host_low = 1'b0; qw();
    scl_drv  = 1'b1; qw();
    ack      = ~sda_line; qw();
    scl_drv  = 1'b0; qw();
  endtask

  task automatic rx8(output logic [7:0] b, input logic give_ack);
    host_low = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      qw();
      scl_drv = 1'b1; qw();
      b = {b[6:0], sda_line}; qw();
      scl_drv = 1'b0;
    end
    host_low = give_ack; qw();
    scl_drv  = 1'b1; qw(); qw();
    scl_drv  = 1'b0; qw();
    host_low = 1'b0;
  endtask

  task automatic byte_write(input int off, input logic [7:0] v, input string tag);
    logic a;
    bus_start();
    tx8(8'hD2, a);                  chk({tag, " address ack"}, {63'b0, a}, 64'd1);
    tx8(8'h80 | 8'(off), a);        chk({tag, " command ack"}, {63'b0, a}, 64'd1);
    tx8(v, a);                      chk({tag, " data ack"},    {63'b0, a}, 64'd1);
    bus_stop();
    model_write(off, v);
    settle();
  endtask

  task automatic byte_read(input int off, input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    tx8(8'hD2, a);                  chk({tag, " address ack"}, {63'b0, a}, 64'd1);
    tx8(8'h80 | 8'(off), a);        chk({tag, " command ack"}, {63'b0, a}, 64'd1);
    bus_start();
    tx8(8'hD3, a);                  chk({tag, " read address ack"}, {63'b0, a}, 64'd1);
    rx8(d, 1'b0);                   chk({tag, " read data"}, 64'(d), 64'(model_read(off)));
    bus_stop();
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired before the sequence ended (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    rst_n    = 1'b0;
    scl_drv  = 1'b1;
    host_low = 1'b0;
    model_defaults();
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset contents byte by byte
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R1 reset value of register %0d", i), 64'(cfg_q[i*8 +: 8]), 64'(mreg[i]));
    chk("R1 sda_oe after reset", {63'b0, sda_oe}, 64'd0);
    mon_en = 1'b1;

    // R4 single write, R5 single reads
    byte_write(2, 8'h5A, "R4 write offset 2");
    byte_read(2, "R5 read offset 2");
    byte_read(0, "R5 read offset 0");

    // R2: foreign addresses are ignored together with what follows
    bus_start();
    tx8(8'hA0, a);  chk("R2 address 0xA0 not acked", {63'b0, a}, 64'd0);
    tx8(8'h81, a);  chk("R2 command after foreign address", {63'b0, a}, 64'd0);
    tx8(8'h00, a);  chk("R2 data after foreign address", {63'b0, a}, 64'd0);
    bus_stop(); settle();
    bus_start();
    tx8(8'hD4, a);  chk("R2 address 0xD4 not acked", {63'b0, a}, 64'd0);
    bus_stop(); settle();

    // R3: chip-select field 01 rejected
    bus_start();
    tx8(8'hD2, a);  chk("R3 address ack", {63'b0, a}, 64'd1);
    tx8(8'hA3, a);  chk("R3 command with select 01 not acked", {63'b0, a}, 64'd0);
    tx8(8'h00, a);  chk("R3 data after rejected command", {63'b0, a}, 64'd0);
    bus_stop(); settle();

    // R6: sequential write of three bytes, early stop
    bus_start();
    tx8(8'hD2, a);  chk("R6 address ack", {63'b0, a}, 64'd1);
    tx8(8'h00, a);  chk("R6 command ack", {63'b0, a}, 64'd1);
    tx8(8'h03, a);  chk("R6 count ack", {63'b0, a}, 64'd1);
    for (int i = 0; i < 3; i++) begin
      tx8(8'h11 * 8'(i + 1), a);
      chk($sformatf("R6 data %0d ack", i), {63'b0, a}, 64'd1);
      model_write(i, 8'h11 * 8'(i + 1));
    end
    bus_stop(); settle();

    // R8, R9: sequential write running past the bank
    bus_start();
    tx8(8'hD2, a);  chk("R9 address ack", {63'b0, a}, 64'd1);
    tx8(8'h00, a);  chk("R9 command ack", {63'b0, a}, 64'd1);
    tx8(8'h0A, a);  chk("R9 count ack", {63'b0, a}, 64'd1);
    for (int i = 0; i < 10; i++) begin
      tx8(8'hA0 + 8'(i), a);
      chk($sformatf("R9 sequential data %0d ack", i), {63'b0, a}, 64'd1);
      model_write(i, 8'hA0 + 8'(i));
    end
    bus_stop(); settle();

    byte_write(7, 8'h55, "R8 write to id register");
    byte_read(7, "R8 read id register");
    byte_write(12, 8'h66, "R9 write offset 12");
    byte_read(12, "R9 read offset 12");

    // R4: extra data bytes after a single write are dropped
    bus_start();
    tx8(8'hD2, a);  chk("R4 address ack", {63'b0, a}, 64'd1);
    tx8(8'h84, a);  chk("R4 command ack", {63'b0, a}, 64'd1);
    tx8(8'h77, a);  chk("R4 first data ack", {63'b0, a}, 64'd1);
    tx8(8'h99, a);  chk("R4 extra data ack", {63'b0, a}, 64'd1);
    model_write(4, 8'h77);
    bus_stop(); settle();

    // R7: sequential read with count, then one byte past the bank (R9)
    bus_start();
    tx8(8'hD2, a);  chk("R7 address ack", {63'b0, a}, 64'd1);
    tx8(8'h00, a);  chk("R7 command ack", {63'b0, a}, 64'd1);
    bus_start();
    tx8(8'hD3, a);  chk("R7 read address ack", {63'b0, a}, 64'd1);
    rx8(d, 1'b1);   chk("R7 returned count", 64'(d), 64'd8);
    for (int i = 0; i < NREG; i++) begin
      rx8(d, 1'b1);
      chk($sformatf("R7 sequential read register %0d", i), 64'(d), 64'(model_read(i)));
    end
    rx8(d, 1'b0);   chk("R9 sequential read past bank", 64'(d), 64'd0);
    // R10: line stays released after the host's not-acknowledge
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R10 released after host nack", {63'b0, sda_oe}, 64'd0);
    end
    bus_stop(); settle();

    // R1: reset in the middle of a sequential write
    bus_start();
    tx8(8'hD2, a);
    tx8(8'h00, a);
    tx8(8'h02, a);
    tx8(8'hEE, a);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    scl_drv  = 1'b1;
    host_low = 1'b0;
    rst_n    = 1'b1;
    model_defaults();
    repeat (8) @(negedge clk);
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R1 value of register %0d after second reset", i),
          64'(cfg_q[i*8 +: 8]), 64'(mreg[i]));
    mon_en = 1'b1;
    byte_read(0, "R1 read register 0 after reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule